// File: doc/BRIEF.md
# Shift, Rotate and Single-Bit Manipulation Unit

This unit carries out the second-page bit-manipulation instructions of an 8-bit processor core on one operand byte. A 2-bit group code and a 3-bit operation code (or bit index) select the operation. The unit receives the operand and the current flag byte. It returns the new operand value, the new flag byte and a write-back enable. Operand fetch and register write-back belong to the surrounding datapath.

The unit also serves the four short-form accumulator rotates. These are requested by raising an accumulator-mode input alongside group 0 and operation codes 0 to 3. In that mode the zero flag is always cleared and is never derived from the result.

The inputs are captured when `in_valid` is high. The results appear on registered outputs one clock later.

Top module: `sbu_core`

## Requirements
- R1: While `rst` is high, and after it, until the first accepted operation, `out_valid`, `wb_en_o`, `result_o` and `flags_o` are all zero.
- R2: An operation accepted with `in_valid` high appears on the outputs on the next rising edge with `out_valid` high. When `in_valid` is low, `out_valid` drops and the other outputs hold their last values.
- R3: The flag byte keeps Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3..0 of `flags_o` are always zero.
- R4: Group 0, op 0 rotates left circularly: bit 7 goes to C and to bit 0. Op 1 rotates right circularly: bit 0 goes to C and to bit 7.
- R5: Group 0, op 2 rotates left through carry: the old C enters bit 0 and bit 7 goes to C. Op 3 rotates right through carry: the old C enters bit 7 and bit 0 goes to C.
- R6: Group 0, op 4 shifts left: bit 7 goes to C and bit 0 becomes 0. Op 5 shifts right arithmetically: bit 7 is kept and bit 0 goes to C. Op 7 shifts right logically: bit 7 becomes 0 and bit 0 goes to C.
- R7: Group 0, op 6 exchanges the upper and lower nibbles and clears C.
- R8: Every group 0 operation clears N and H. Outside accumulator mode, Z is set exactly when the 8-bit result is zero.
- R9: Group 1 tests bit `sel_i`. Z is set when that bit is 0, H is set, N is cleared and C keeps its incoming value. `result_o` equals the operand unchanged.
- R10: Group 2 clears bit `sel_i` and group 3 sets bit `sel_i`. For both groups, `flags_o[7:4]` equals the incoming `flags_i[7:4]`.
- R11: `wb_en_o` is 1 for groups 0, 2 and 3, and 0 for group 1.
- R12: With `acc_mode_i` high, group 0 and op 0..3, the result and C are the same as in R4/R5, N and H are cleared, and Z is forced to 0. With any other group or op, `acc_mode_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operation on this edge |
| grp_i | input | 2 | Group: 0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set |
| sel_i | input | 3 | Operation code (group 0) or bit index (groups 1..3) |
| acc_mode_i | input | 1 | Short-form accumulator rotate: Z forced clear |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte (Z7 N6 H5 C4) |
| out_valid | output | 1 | Outputs hold a freshly computed result |
| result_o | output | 8 | New operand value |
| flags_o | output | 8 | New flag byte, low nibble zero |
| wb_en_o | output | 1 | Result should be written back |

## Verification
Two functions can meet in one cycle. The first is the accumulator-mode zero clearing. The second is the result-derived zero flag of the shift and rotate group, and both apply to the same operation code. The bench provokes this overlap with operands whose rotated result is zero, for example a through-carry left rotate of 0x80 with carry clear. The same operand is run once with the accumulator mode and once without, and the two flag bytes must differ only in Z. The bench also raises the accumulator mode with the shift-left code and with the bit-set group. Here it expects the flags that the mode-free operation would give, which confirms that the mode is ignored outside the four rotates.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int FLAG_W = 8;
  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    OP_ROLC = 3'd0,
    OP_RORC = 3'd1,
    OP_ROLT = 3'd2,
    OP_RORT = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHRA = 3'd5,
    OP_NSWP = 3'd6,
    OP_SHRL = 3'd7
  } shop_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  function automatic logic [FLAG_W-1:0] pack_flags(flags_t f);
    logic [FLAG_W-1:0] v;
    v = '0;
    v[FZ] = f.z;
    v[FN] = f.n;
    v[FH] = f.h;
    v[FC] = f.c;
    return v;
  endfunction
endpackage

// File: rtl/sbu_shift.sv
module sbu_shift
  import sbu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_i,
  input  logic [2:0]   code_i,
  input  logic         cin_i,
  input  logic         acc_i,
  output logic [W-1:0] res_o,
  output flags_t       fl_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;
  logic         cout;

  genvar gi;
  generate
    for (gi = 0; gi < HALF; gi++) begin : g_swap
      assign swapped[gi]        = op_i[gi + HALF];
      assign swapped[gi + HALF] = op_i[gi];
    end
  endgenerate

  always_comb begin
    res_o = op_i;
    cout  = 1'b0;
    case (shop_e'(code_i))
      OP_ROLC: begin res_o = {op_i[W-2:0], op_i[W-1]}; cout = op_i[W-1]; end
      OP_RORC: begin res_o = {op_i[0], op_i[W-1:1]};   cout = op_i[0];   end
      OP_ROLT: begin res_o = {op_i[W-2:0], cin_i};     cout = op_i[W-1]; end
      OP_RORT: begin res_o = {cin_i, op_i[W-1:1]};     cout = op_i[0];   end
      OP_SHL:  begin res_o = {op_i[W-2:0], 1'b0};      cout = op_i[W-1]; end
      OP_SHRA: begin res_o = {op_i[W-1], op_i[W-1:1]}; cout = op_i[0];   end
      OP_NSWP: begin res_o = swapped;                  cout = 1'b0;      end
      OP_SHRL: begin res_o = {1'b0, op_i[W-1:1]};      cout = op_i[0];   end
      default: begin res_o = op_i;                     cout = 1'b0;      end
    endcase
  end

  logic acc_rot;
  assign acc_rot = acc_i && (code_i[2] == 1'b0);

  always_comb begin
    fl_o.z = acc_rot ? 1'b0 : (res_o == '0);
    fl_o.n = 1'b0;
    fl_o.h = 1'b0;
    fl_o.c = cout;
  end
endmodule

// File: rtl/sbu_bitop.sv
module sbu_bitop
  import sbu_pkg::*;
#(
  parameter int W = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       grp_i,
  output logic [W-1:0]     res_o,
  output logic             bit_zero_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[idx_i] = 1'b1;
  end

  assign bit_zero_o = ((op_i & mask) == '0);

  always_comb begin
    case (grp_e'(grp_i))
      GRP_CLR: res_o = op_i & ~mask;
      GRP_SET: res_o = op_i | mask;
      default: res_o = op_i;
    endcase
  end
endmodule

// File: rtl/sbu_core.sv
module sbu_core
  import sbu_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W),
  localparam int SEL_W = (IDX_W > 3) ? IDX_W : 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        grp_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              acc_mode_i,
  input  logic [W-1:0]      operand_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              out_valid,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              wb_en_o
);
  flags_t       fin;
  logic [W-1:0] sh_res;
  flags_t       sh_fl;
  logic [W-1:0] bo_res;
  logic         bo_zero;

  assign fin.z = flags_i[FZ];
  assign fin.n = flags_i[FN];
  assign fin.h = flags_i[FH];
  assign fin.c = flags_i[FC];

  sbu_shift #(.W(W)) u_shift (
    .op_i   (operand_i),
    .code_i (sel_i[2:0]),
    .cin_i  (fin.c),
    .acc_i  (acc_mode_i),
    .res_o  (sh_res),
    .fl_o   (sh_fl)
  );

  sbu_bitop #(.W(W), .IDX_W(IDX_W)) u_bitop (
    .op_i       (operand_i),
    .idx_i      (sel_i[IDX_W-1:0]),
    .grp_i      (grp_i),
    .res_o      (bo_res),
    .bit_zero_o (bo_zero)
  );

  logic [W-1:0]      nx_res;
  flags_t            nx_fl;
  logic              nx_wb;

  always_comb begin
    nx_res = bo_res;
    nx_fl  = fin;
    nx_wb  = 1'b1;
    case (grp_e'(grp_i))
      GRP_SHIFT: begin
        nx_res = sh_res;
        nx_fl  = sh_fl;
      end
      GRP_TEST: begin
        nx_fl.z = bo_zero;
        nx_fl.n = 1'b0;
        nx_fl.h = 1'b1;
        nx_fl.c = fin.c;
        nx_wb   = 1'b0;
      end
      default: begin
        nx_fl = fin;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      wb_en_o   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result_o <= nx_res;
        flags_o  <= pack_flags(nx_fl);
        wb_en_o  <= nx_wb;
      end
    end
  end

  assert_flag_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    flags_o[3:0] == 4'b0);

  assert_test_no_wb_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_i == 2'd1) |=> !wb_en_o);

  assert_test_keeps_c_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_i == 2'd1) |=> (flags_o[FC] == $past(flags_i[FC]) && flags_o[FH]));

  assert_clrset_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_i[1]) |=> (flags_o[7:4] == $past(flags_i[7:4])));

  assert_acc_rot_zclr_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_i == 2'd0 && acc_mode_i && sel_i[2] == 1'b0) |=> !flags_o[FZ]);

  assert_swap_cclr_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_i == 2'd0 && sel_i[2:0] == 3'd6) |=> !flags_o[FC]);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> ($stable(result_o) && $stable(flags_o) && !out_valid));
endmodule

// File: tb/tb_sbu_core.sv
`timescale 1ns/1ps
module tb_sbu_core;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [1:0] grp_i;
  logic [2:0] sel_i;
  logic       acc_mode_i;
  logic [7:0] operand_i;
  logic [7:0] flags_i;
  logic       out_valid;
  logic [7:0] result_o;
  logic [7:0] flags_o;
  logic       wb_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sbu_core dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .grp_i(grp_i), .sel_i(sel_i),
    .acc_mode_i(acc_mode_i), .operand_i(operand_i), .flags_i(flags_i),
    .out_valid(out_valid), .result_o(result_o), .flags_o(flags_o), .wb_en_o(wb_en_o)
  );

  // Expected {wb, flags, result} from the requirements
  function automatic logic [16:0] model(input logic [1:0] g, input logic [2:0] s,
                                        input logic acc, input logic [7:0] op,
                                        input logic [7:0] fl);
    logic [7:0] r;
    logic nc, z, c;
    logic [7:0] f;
    c = fl[4];
    r = op; nc = 1'b0; f = 8'h00;
    case (g)
      2'd0: begin
        case (s)
          3'd0: begin r = {op[6:0], op[7]}; nc = op[7]; end
          3'd1: begin r = {op[0], op[7:1]}; nc = op[0]; end
          3'd2: begin r = {op[6:0], c};     nc = op[7]; end
          3'd3: begin r = {c, op[7:1]};     nc = op[0]; end
          3'd4: begin r = {op[6:0], 1'b0};  nc = op[7]; end
          3'd5: begin r = {op[7], op[7:1]}; nc = op[0]; end
          3'd6: begin r = {op[3:0], op[7:4]}; nc = 1'b0; end
          default: begin r = {1'b0, op[7:1]}; nc = op[0]; end
        endcase
        z = (acc && s < 3'd4) ? 1'b0 : (r == 8'h00);
        f = {z, 1'b0, 1'b0, nc, 4'h0};
        return {1'b1, f, r};
      end
      2'd1: begin
        f = {~op[s], 1'b0, 1'b1, c, 4'h0};
        return {1'b0, f, op};
      end
      2'd2: return {1'b1, fl[7:4], 4'h0, op & ~(8'h01 << s)};
      default: return {1'b1, fl[7:4], 4'h0, op | (8'h01 << s)};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] g, input logic [2:0] s,
                        input logic acc, input logic [7:0] op, input logic [7:0] fl);
    logic [16:0] e;
    e = model(g, s, acc, op, fl);
    @(negedge clk);
    in_valid = 1'b1; grp_i = g; sel_i = s; acc_mode_i = acc; operand_i = op; flags_i = fl;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " result"}, {24'h0, result_o}, {24'h0, e[7:0]});
    check({tag, " flags"},  {24'h0, flags_o},  {24'h0, e[15:8]});
    check({tag, " wb R11"}, {31'h0, wb_en_o},  {31'h0, e[16]});
    check({tag, " valid R2"}, {31'h0, out_valid}, 32'h1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", {31'h0, out_valid}, 32'h0);
    check("R1 result", {24'h0, result_o}, 32'h0);
    check("R1 flags", {24'h0, flags_o}, 32'h0);
    check("R1 wb", {31'h0, wb_en_o}, 32'h0);
  endtask

  task automatic t_circ;
    run_op("R4 rolc 85", 2'd0, 3'd0, 1'b0, 8'h85, 8'h00);
    run_op("R4 rorc 01", 2'd0, 3'd1, 1'b0, 8'h01, 8'h00);
    run_op("R4 rolc 00", 2'd0, 3'd0, 1'b0, 8'h00, 8'h10);
  endtask

  task automatic t_thru;
    run_op("R5 rolt 80 c0", 2'd0, 3'd2, 1'b0, 8'h80, 8'h00);
    run_op("R5 rolt 40 c1", 2'd0, 3'd2, 1'b0, 8'h40, 8'h10);
    run_op("R5 rort 01 c1", 2'd0, 3'd3, 1'b0, 8'h01, 8'h10);
  endtask

  task automatic t_shifts;
    run_op("R6 shl c3", 2'd0, 3'd4, 1'b0, 8'hC3, 8'h00);
    run_op("R6 shra 81", 2'd0, 3'd5, 1'b0, 8'h81, 8'h00);
    run_op("R6 shrl 81", 2'd0, 3'd7, 1'b0, 8'h81, 8'h00);
    run_op("R6 shrl 01", 2'd0, 3'd7, 1'b0, 8'h01, 8'h00);
  endtask

  task automatic t_swap;
    run_op("R7 swap a5 c1", 2'd0, 3'd6, 1'b0, 8'hA5, 8'h10);
    run_op("R7 swap 00", 2'd0, 3'd6, 1'b0, 8'h00, 8'hF0);
  endtask

  task automatic t_nh;
    run_op("R8 nh clear", 2'd0, 3'd0, 1'b0, 8'h12, 8'h60);
    run_op("R3 low nibble", 2'd0, 3'd5, 1'b0, 8'h02, 8'hFF);
  endtask

  task automatic t_test;
    run_op("R9 bit3 of 08", 2'd1, 3'd3, 1'b0, 8'h08, 8'h00);
    run_op("R9 bit7 of 7f c1", 2'd1, 3'd7, 1'b0, 8'h7F, 8'h1F);
    run_op("R9 bit0 of fe c0", 2'd1, 3'd0, 1'b0, 8'hFE, 8'hC0);
  endtask

  task automatic t_clrset;
    run_op("R10 clr0 ff", 2'd2, 3'd0, 1'b0, 8'hFF, 8'hB0);
    run_op("R10 set7 00", 2'd3, 3'd7, 1'b0, 8'h00, 8'h5F);
  endtask

  task automatic t_acc;
    logic [7:0] f_pref;
    run_op("R12 acc rolt 80", 2'd0, 3'd2, 1'b1, 8'h80, 8'h00);
    run_op("R8 pref rolt 80", 2'd0, 3'd2, 1'b0, 8'h80, 8'h00);
    f_pref = flags_o;
    run_op("R12 acc rolt 80 again", 2'd0, 3'd2, 1'b1, 8'h80, 8'h00);
    check("R12 only Z differs", {24'h0, flags_o ^ f_pref}, 32'h80);
    run_op("R12 acc ignored shl", 2'd0, 3'd4, 1'b1, 8'h80, 8'h00);
    run_op("R12 acc ignored set", 2'd3, 3'd1, 1'b1, 8'h00, 8'h80);
    run_op("R12 acc ignored test", 2'd1, 3'd2, 1'b1, 8'h00, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] r0, f0;
    run_op("R2 before idle", 2'd0, 3'd0, 1'b0, 8'h81, 8'h00);
    r0 = result_o; f0 = flags_o;
    @(negedge clk);
    grp_i = 2'd3; sel_i = 3'd5; operand_i = 8'h00; flags_i = 8'hF0;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle valid", {31'h0, out_valid}, 32'h0);
    check("R2 idle result", {24'h0, result_o}, {24'h0, r0});
    check("R2 idle flags", {24'h0, flags_o}, {24'h0, f0});
  endtask

  task automatic t_sweep;
    logic [7:0] ops [4];
    ops[0] = 8'h00; ops[1] = 8'hFF; ops[2] = 8'h5A; ops[3] = 8'h81;
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 4; k++)
          run_op("R4 R5 R6 R7 R8 R9 R10 R11 sweep", 2'(g), 3'(s), 1'b0, ops[k],
                 (k[0] ? 8'hF0 : 8'h00));
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; grp_i = 2'd0; sel_i = 3'd0; acc_mode_i = 1'b0;
    operand_i = 8'h00; flags_i = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_circ();
    t_thru();
    t_shifts();
    t_swap();
    t_nh();
    t_test();
    t_clrset();
    t_acc();
    t_hold();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule